// File: doc/BRIEF.md
# Triggered PWM Timer

This block is a 16-bit up-counter with a power-of-two prescaler and a compare-based output. The count is started in one of two ways: by a start strobe from software, or by a chosen edge on an asynchronous trigger pin. The counter always runs from 0 up to a reload value. In one-shot operation it returns to 0 and stops there. In continuous operation it wraps back to 0 and keeps going. Two further options change how later triggers are handled. The first-trigger-only option ignores every trigger after the first one. The restart-on-trigger option returns the running count to 0 on each accepted trigger, which makes a watchdog-like timeout.

The output waveform compares the count with a compare value and can be inverted by a polarity input. The block also gives single-cycle pulses when the count reaches the compare value, when it reaches the reload value, and when a trigger is accepted. A start strobe has two jobs: it arms the block and it picks the operating mode. Because a strobe also sets the mode, it can change the mode while the counter is running.

Top module: `trig_pwm_timer`

## Requirements
- R1: After reset, and at any time the enable input is low, the count reads 0, no event pulse fires, and a start strobe given while disabled has no effect once the block is enabled again.
- R2: With start source 00 (software), a start strobe begins the count. With division by 1, the count reads 0 up to the third rising edge (counting the edge that samples the strobe) and reads 1 after the fourth.
- R3: The start source selects the trigger edge: 01 is rising, 10 is falling, 11 is both. An accepted edge raises trig_ok_o for one cycle after the third rising clock edge (counting the edge that samples the pin), and with division by 1 the count reads 1 after the fifth. An edge of a direction that is not selected does nothing.
- R4: In one-shot mode the count goes 0..reload, returns to 0 and stops. A trigger that arrives while it runs is discarded and gives no trig_ok_o. A trigger that arrives after it stops starts a new run.
- R5: In continuous mode the count wraps from the reload value to 0 without stopping.
- R6: With first-trigger-only set, only the first trigger after a start strobe is accepted. Every later trigger is discarded.
- R7: With restart-on-trigger set, a trigger accepted while running returns the count to 0 on the next edge, counting continues from there, and trig_ok_o pulses.
- R8: A continuous strobe issued during a one-shot run makes the counter wrap at the reload value. A single strobe issued during continuous counting makes it stop at the next reload match.
- R9: A prescale value N makes the count advance once every 2^N clock cycles (N from 0 to 7).
- R10: wave_o equals (count >= compare) XOR polarity. A change of polarity shows at once, also while disabled.
- R11: cmp_match_o and arr_match_o fire for one cycle on the count step where the running count equals the compare value and the reload value respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; low clears and stops |
| start_one_i | input | 1 | Single-run start strobe |
| start_cont_i | input | 1 | Continuous-run start strobe |
| trig_i | input | 1 | Asynchronous trigger pin |
| trig_src_i | input | 2 | 00 software, 01 rise, 10 fall, 11 both |
| set_once_i | input | 1 | Accept only the first trigger after a strobe |
| timeout_i | input | 1 | Restart the count on each trigger while running |
| pol_i | input | 1 | Inverts wave_o |
| psc_i | input | 3 | Clock division exponent N |
| cmp_i | input | 16 | Compare value |
| arr_i | input | 16 | Reload value |
| cnt_o | output | 16 | Counter value |
| wave_o | output | 1 | Compare waveform |
| cmp_match_o | output | 1 | Compare match pulse |
| arr_match_o | output | 1 | Reload match pulse |
| trig_ok_o | output | 1 | Accepted trigger pulse |

## Verification
The assertions check the following on every cycle:
- The block stops when disabled.
- The count holds its value between ticks and otherwise steps by one.
- A one-shot run ends at reload and a continuous run never ends.
- A trigger is accepted while running only when restart-on-trigger is set.
- A trigger is never accepted once the first-trigger-only option has used its one start.
- The prescaler tick never fires on two cycles in a row.

The exact start latencies, the mode switches in mid-run, the edge selection and the cycle of each event pulse cannot be checked that way. Only the bench scenarios show them, because the expected timing is predicted in the bench and compared against the event stream.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    // Start source encoding (also the trigger edge selection)
    typedef enum logic [1:0] {
        SRC_SOFT = 2'b00,
        SRC_RISE = 2'b01,
        SRC_FALL = 2'b10,
        SRC_BOTH = 2'b11
    } start_src_e;

    typedef struct packed {
        logic cmp;
        logic arr;
    } match_t;

    function automatic logic edge_seen(start_src_e src, logic now_l, logic was_l);
        case (src)
            SRC_RISE: return now_l & ~was_l;
            SRC_FALL: return ~now_l & was_l;
            SRC_BOTH: return now_l ^ was_l;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptt_trig_edge.sv
module ptt_trig_edge
    import ptt_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    input  start_src_e src_i,
    output logic       edge_o
);
    // SYNC flops resynchronise the pin, one more holds the previous level
    logic [SYNC:0] shf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q  <= '0;
            edge_o <= 1'b0;
        end else begin
            shf_q  <= {shf_q[SYNC-1:0], trig_i};
            edge_o <= edge_seen(src_i, shf_q[SYNC-1], shf_q[SYNC]);
        end
    end
endmodule

// File: rtl/ptt_prescale.sv
module ptt_prescale #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = DIV_W'((32'd1 << psc_i) - 32'd1);
        tick_o = run_i && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || clr_i) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    // R9: with division above 1, two ticks never fall on adjacent cycles
    p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
        tick_o && (psc_i != '0) |=> !tick_o || (psc_i != $past(psc_i)));
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter
    import ptt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         clr_i,
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] arr_i,
    output logic [W-1:0] cnt_o,
    output match_t       match_o
);
    logic step;

    always_comb begin
        step        = run_i && tick_i;
        match_o.cmp = step && (cnt_o == cmp_i);
        match_o.arr = step && (cnt_o == arr_i);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_o <= '0;
        else if (step)     cnt_o <= (cnt_o == arr_i) ? '0 : cnt_o + 1'b1;
    end

    // R9: between ticks the count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_i && !clr_i |=> $stable(cnt_o));
    // R5: on a tick below the reload value the count steps by one
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        step && !clr_i && (cnt_o != arr_i) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/ptt_seq.sv
module ptt_seq
    import ptt_pkg::*;
#(
    parameter int SW_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       str_one_i,
    input  logic       str_cont_i,
    input  start_src_e src_i,
    input  logic       set_once_i,
    input  logic       timeout_i,
    input  logic       edge_i,
    input  logic       arr_hit_i,
    output logic       run_o,
    output logic       restart_o,
    output logic       accept_o
);
    logic                 armed_q, cont_q, used_q;
    logic [SW_STAGES-1:0] sw_q;
    logic                 strobe;

    always_comb begin
        strobe    = str_one_i || str_cont_i;
        accept_o  = edge_i && armed_q && (src_i != SRC_SOFT) &&
                    (run_o ? timeout_i : !(set_once_i && used_q));
        restart_o = accept_o && run_o;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            armed_q <= 1'b0;
            cont_q  <= 1'b0;
            used_q  <= 1'b0;
            sw_q    <= '0;
            run_o   <= 1'b0;
        end else begin
            if (strobe) begin
                armed_q <= 1'b1;
                used_q  <= 1'b0;
                cont_q  <= str_cont_i;
            end
            sw_q <= {sw_q[SW_STAGES-2:0], strobe && (src_i == SRC_SOFT)};
            if (accept_o) used_q <= 1'b1;
            if (run_o) begin
                if (arr_hit_i && !cont_q && !restart_o) run_o <= 1'b0;
            end else if (sw_q[SW_STAGES-1] || accept_o) begin
                run_o <= 1'b1;
            end
        end
    end

    // R1: disabling stops the counter
    p_off_r1: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !run_o);
    // R4: a one-shot run ends at the reload match
    p_oneshot_end_r4: assert property (@(posedge clk) disable iff (rst)
        run_o && arr_hit_i && !cont_q && !accept_o |=> !run_o);
    // R5: continuous counting does not stop while enabled
    p_cont_run_r5: assert property (@(posedge clk) disable iff (rst)
        run_o && cont_q && en_i |=> run_o);
    // R4: a trigger is taken while running only for a timeout restart
    p_discard_r4: assert property (@(posedge clk) disable iff (rst)
        accept_o && run_o |-> timeout_i);
    // R6: once used, the first-trigger-only start accepts nothing more
    p_setonce_r6: assert property (@(posedge clk) disable iff (rst)
        set_once_i && used_q && !run_o |-> !accept_o);
endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer
    import ptt_pkg::*;
#(
    parameter int W     = 16,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             start_one_i,
    input  logic             start_cont_i,
    input  logic             trig_i,
    input  logic [1:0]       trig_src_i,
    input  logic             set_once_i,
    input  logic             timeout_i,
    input  logic             pol_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [W-1:0]     cmp_i,
    input  logic [W-1:0]     arr_i,
    output logic [W-1:0]     cnt_o,
    output logic             wave_o,
    output logic             cmp_match_o,
    output logic             arr_match_o,
    output logic             trig_ok_o
);
    start_src_e src;
    logic       edge_q, run, restart, tick, cnt_clr;
    match_t     hit;

    assign src     = start_src_e'(trig_src_i);
    assign cnt_clr = !en_i || restart;

    ptt_trig_edge #(.SYNC(2)) u_edge (
        .clk(clk), .rst(rst), .trig_i(trig_i), .src_i(src), .edge_o(edge_q)
    );

    ptt_seq #(.SW_STAGES(2)) u_seq (
        .clk(clk), .rst(rst), .en_i(en_i),
        .str_one_i(start_one_i), .str_cont_i(start_cont_i),
        .src_i(src), .set_once_i(set_once_i), .timeout_i(timeout_i),
        .edge_i(edge_q), .arr_hit_i(hit.arr),
        .run_o(run), .restart_o(restart), .accept_o(trig_ok_o)
    );

    ptt_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .run_i(run), .clr_i(restart),
        .psc_i(psc_i), .tick_o(tick)
    );

    ptt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run_i(run), .tick_i(tick), .clr_i(cnt_clr),
        .cmp_i(cmp_i), .arr_i(arr_i), .cnt_o(cnt_o), .match_o(hit)
    );

    always_comb begin
        cmp_match_o = hit.cmp;
        arr_match_o = hit.arr;
        wave_o      = (cnt_o >= cmp_i) ^ pol_i;
    end

    // R1: an idle counter reads zero
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> cnt_o == '0);
    // R11: match pulses only while counting
    p_pulse_run_r11: assert property (@(posedge clk) disable iff (rst)
        (cmp_match_o || arr_match_o) |-> run);
endmodule

// File: tb/tb_trig_pwm_timer.sv
module tb_trig_pwm_timer;
    localparam int W = 16;
    localparam int K_TRIG = 0, K_CMP = 1, K_ARR = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 0, s_one = 0, s_cont = 0, trig = 0, so = 0, to = 0, pol = 0;
    logic [1:0]   src = 0;
    logic [2:0]   psc = 0;
    logic [W-1:0] cmp = 0, arr = 0;
    logic [W-1:0] cnt;
    logic         wave, cmp_m, arr_m, trig_ok;

    always #4 clk = ~clk;

    trig_pwm_timer dut (
        .clk(clk), .rst(rst), .en_i(en), .start_one_i(s_one), .start_cont_i(s_cont),
        .trig_i(trig), .trig_src_i(src), .set_once_i(so), .timeout_i(to), .pol_i(pol),
        .psc_i(psc), .cmp_i(cmp), .arr_i(arr), .cnt_o(cnt), .wave_o(wave),
        .cmp_match_o(cmp_m), .arr_match_o(arr_m), .trig_ok_o(trig_ok)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    typedef struct { int kind; int at; string req; } exp_t;
    exp_t q[$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, int at, string req);
        q.push_back('{kind, at, req});
    endtask

    // Monitor: every observed pulse must match the head of the queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int k = 0; k < 3; k++) begin
                    bit fired;
                    fired = (k == K_TRIG) ? trig_ok : (k == K_CMP) ? cmp_m : arr_m;
                    if (fired) begin
                        if (q.size() == 0) chk(0, "R11", "unexpected event kind*100000+cycle",
                                               k * 100000 + cyc, -1);
                        else begin
                            exp_t e;
                            e = q.pop_front();
                            chk(e.kind == k && e.at == cyc, e.req, "event kind*100000+cycle",
                                k * 100000 + cyc, e.kind * 100000 + e.at);
                        end
                    end
                end
            end
        end
    end

    task automatic wait_until(int t);
        while (cyc < t) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_start(bit cont, output int e);
        @(negedge clk); #1;
        if (cont) s_cont = 1; else s_one = 1;
        e = cyc + 1;
        @(negedge clk); #1;
        s_cont = 0; s_one = 0;
    endtask

    task automatic set_trig_at(bit v, int e);
        wait_until(e - 1);
        trig = v;
    endtask

    task automatic chk_cnt_at(int t, string req, int exp);
        wait_until(t);
        chk(cnt == W'(exp), req, "count", int'(cnt), exp);
    endtask

    task automatic setup(logic [1:0] s, bit o, bit t, bit p, logic [2:0] n, int c, int a);
        @(negedge clk); #1;
        en = 0;
        @(negedge clk); #1;
        src = s; so = o; to = t; pol = p; psc = n; cmp = W'(c); arr = W'(a);
        @(negedge clk); #1;
        en = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, e, t0;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1: reset state
        @(negedge clk); #1;
        chk(cnt == 0, "R1", "count after reset", int'(cnt), 0);
        chk({cmp_m, arr_m, trig_ok} == 3'b000, "R1", "pulses after reset",
            int'({cmp_m, arr_m, trig_ok}), 0);

        // R10: polarity acts at once while disabled; R1: strobe while disabled ignored
        cmp = 2; pol = 0; #1;
        chk(wave == 0, "R10", "wave pol0 idle", int'(wave), 0);
        pol = 1; #1;
        chk(wave == 1, "R10", "wave pol1 idle", int'(wave), 1);
        pol = 0;
        pulse_start(0, e);
        @(negedge clk); #1; en = 1;
        chk_cnt_at(cyc + 6, "R1", 0);

        // Software one-shot, division by 1
        setup(2'b00, 0, 0, 0, 3'd0, 2, 5);
        pulse_start(0, c0);
        expect_ev(K_CMP, c0 + 4, "R11");
        expect_ev(K_ARR, c0 + 7, "R4");
        chk_cnt_at(c0 + 2, "R2", 0);
        chk_cnt_at(c0 + 3, "R2", 1);
        chk(wave == 0, "R10", "wave below compare", int'(wave), 0);
        wait_until(c0 + 5);
        chk(wave == 1, "R10", "wave above compare", int'(wave), 1);
        chk_cnt_at(c0 + 10, "R4", 0);

        // Division by 2, one-shot switched to continuous, then back to one-shot
        setup(2'b00, 0, 0, 0, 3'd1, 1, 3);
        pulse_start(0, c0);
        expect_ev(K_CMP, c0 + 5, "R9");
        chk_cnt_at(c0 + 3, "R9", 0);
        chk_cnt_at(c0 + 4, "R9", 1);
        pulse_start(1, e);
        expect_ev(K_ARR, c0 + 9, "R8");
        expect_ev(K_CMP, c0 + 13, "R5");
        expect_ev(K_ARR, c0 + 17, "R5");
        wait_until(c0 + 17);
        pulse_start(0, e);
        expect_ev(K_CMP, c0 + 21, "R8");
        expect_ev(K_ARR, c0 + 25, "R8");
        chk_cnt_at(c0 + 28, "R8", 0);

        // Rising-edge trigger, one-shot, discards during run
        setup(2'b01, 0, 0, 0, 3'd0, 1, 9);
        pulse_start(0, e);
        t0 = cyc + 2;
        set_trig_at(1, t0);
        expect_ev(K_TRIG, t0 + 2, "R3");
        expect_ev(K_CMP, t0 + 4, "R11");
        expect_ev(K_ARR, t0 + 12, "R4");
        chk_cnt_at(t0 + 4, "R3", 1);
        set_trig_at(0, t0 + 5);
        set_trig_at(1, t0 + 7);
        chk_cnt_at(t0 + 10, "R4", 7);
        set_trig_at(0, t0 + 14);
        chk_cnt_at(t0 + 17, "R3", 0);
        set_trig_at(1, t0 + 18);
        expect_ev(K_TRIG, t0 + 20, "R4");
        expect_ev(K_CMP, t0 + 22, "R11");
        expect_ev(K_ARR, t0 + 30, "R4");
        chk_cnt_at(t0 + 32, "R4", 0);

        // Falling-edge trigger with first-trigger-only
        setup(2'b10, 1, 0, 0, 3'd0, 1, 2);
        pulse_start(0, e);
        t0 = cyc + 2;
        set_trig_at(0, t0);
        expect_ev(K_TRIG, t0 + 2, "R6");
        expect_ev(K_CMP, t0 + 4, "R11");
        expect_ev(K_ARR, t0 + 5, "R4");
        set_trig_at(1, t0 + 8);
        set_trig_at(0, t0 + 10);
        chk_cnt_at(t0 + 15, "R6", 0);

        // Both edges with restart-on-trigger
        setup(2'b11, 0, 1, 0, 3'd0, 5, 9);
        pulse_start(0, e);
        t0 = cyc + 2;
        set_trig_at(1, t0);
        expect_ev(K_TRIG, t0 + 2, "R7");
        expect_ev(K_TRIG, t0 + 6, "R7");
        expect_ev(K_CMP, t0 + 12, "R7");
        expect_ev(K_ARR, t0 + 16, "R7");
        set_trig_at(0, t0 + 4);
        chk_cnt_at(t0 + 6, "R7", 3);
        chk_cnt_at(t0 + 7, "R7", 0);
        chk_cnt_at(t0 + 18, "R7", 0);

        wait_until(cyc + 4);
        chk(q.size() == 0, "R11", "pending expected events", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule